// File: doc/BRIEF.md
# 24-bit Framed Serial Word Link

This block pairs a serial transmitter and a serial receiver that move 24-bit words over a single wire in each direction. Each frame starts with one high marker bit. The 24 payload bits follow at once, most significant bit first and high-true, with NRZ coding and no trailing stop or parity bit. Between frames the wire rests low.

The transmitter takes a parallel word through a valid/ready handshake and shifts it out. Each bit lasts a fixed number of system clocks, and that number is a parameter. The receiver samples its wire on a divided tick and oversamples each bit by a parameterized factor. It looks for a high level, confirms the marker at its midpoint, then takes each payload bit near its centre. It holds the finished word with a valid flag until the user reads it.

The two directions have independent rate parameters, so one instance can send slowly and receive ten times faster. If a new word arrives before the previous one has been read, the receiver raises a sticky overrun flag.

Transmitter states: TX_IDLE (line low, ready high) goes to TX_START on an accepted word. TX_START (line high) goes to TX_DATA after one bit period. TX_DATA steps down through the bits and returns to TX_IDLE after bit 0.

Receiver states: RX_HUNT goes to RX_START_CHK when a tick sees the line high. RX_START_CHK goes to RX_DATA when the line is still high at the midpoint, and back to RX_HUNT when it is not. RX_DATA goes to RX_DRAIN after the 24th sample. RX_DRAIN goes to RX_HUNT when a tick sees the line low.

Top module: `serial_word_link`

## Requirements
- R1: After reset, tx_line is 0, tx_ready is 1, rx_valid is 0 and rx_overrun is 0.
- R2: A word is accepted on the rising clock edge where tx_valid and tx_ready are both 1. tx_ready then stays 0 for exactly 25*TX_CLKS_PER_BIT cycles and returns to 1 on the following cycle.
- R3: While tx_ready is 1, tx_line is 0 (the line idles low).
- R4: The transmitted frame is a high marker bit followed by the accepted word. The word's bit 23 goes first and bit 0 last, a 1 bit is sent as a high level, and each bit lasts TX_CLKS_PER_BIT cycles. There is no stop or parity bit.
- R5: The receiver has a bit period of RX_TICK_DIV*RX_OVS clocks. When it receives a valid frame whose sender leaves the line low for at least one bit period afterwards, it sets rx_valid and places the 24 payload bits on rx_data, with the first bit received in bit 23.
- R6: rx_valid and rx_data hold until rx_rd is 1 at a clock edge, which clears rx_valid.
- R7: A high level on rx_line that is no longer high at the marker midpoint is rejected. A high pulse shorter than a quarter of a bit period produces no word.
- R8: If a new word completes while rx_valid is 1 and rx_rd is 0, rx_overrun becomes 1 and rx_data takes the newer word.
- R9: rx_overrun stays 1 until ovr_clr is 1 at a clock edge with no new overrun in the same cycle. A new overrun wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 24 | Word to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter can accept a word |
| tx_line | output | 1 | Serial output line |
| rx_line | input | 1 | Serial input line |
| rx_data | output | 24 | Last received word |
| rx_valid | output | 1 | rx_data holds an unread word |
| rx_rd | input | 1 | Read strobe that clears rx_valid |
| rx_overrun | output | 1 | Sticky flag for a word that arrived while one was unread |
| ovr_clr | input | 1 | Clears rx_overrun |

## Verification
On every cycle, the assertions check the idle-low line, the start of the marker bit right after a handshake, that rx_valid persists until it is read, that rx_overrun is sticky, and that an overrun only appears together with a held word. Other properties need scenarios from the bench. These are the exact frame length, the MSB-first bit order on the wire, and a loopback of several words, including all-zero and all-one words. The bench also covers rejection of a short glitch, and an overrun that keeps the newer word and is then cleared.

// File: rtl/link_pkg.sv
package link_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START_CHK,
        RX_DATA,
        RX_DRAIN
    } rx_state_e;

endpackage

// File: rtl/link_tick_gen.sv
module link_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (restart || cnt_q == CW'(DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick = (cnt_q == CW'(DIV - 1)) && !restart;
        end
    endgenerate
endmodule

// File: rtl/link_tx.sv
module link_tx
    import link_pkg::*;
#(
    parameter int WORD_W       = 24,
    parameter int CLKS_PER_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              line
);
    localparam int IW = $clog2(WORD_W);

    tx_state_e         st_q, st_d;
    logic [WORD_W-1:0] sh_q, sh_d;
    logic [IW-1:0]     idx_q, idx_d;
    logic              load;
    logic              bit_tick;

    assign load = valid && (st_q == TX_IDLE);

    link_tick_gen #(.DIV(CLKS_PER_BIT)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (bit_tick)
    );

    always_comb begin
        st_d  = st_q;
        sh_d  = sh_q;
        idx_d = idx_q;
        unique case (st_q)
            TX_IDLE: begin
                if (valid) begin
                    sh_d  = data;
                    idx_d = IW'(WORD_W - 1);
                    st_d  = TX_START;
                end
            end
            TX_START: begin
                if (bit_tick) st_d = TX_DATA;
            end
            TX_DATA: begin
                if (bit_tick) begin
                    if (idx_q == '0) begin
                        st_d = TX_IDLE;
                    end else begin
                        idx_d = idx_q - 1'b1;
                        sh_d  = {sh_q[WORD_W-2:0], 1'b0};
                    end
                end
            end
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            sh_q  <= '0;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            sh_q  <= sh_d;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        ready = 1'b0;
        line  = 1'b0;
        unique case (st_q)
            TX_IDLE:  ready = 1'b1;
            TX_START: line  = 1'b1;
            TX_DATA:  line  = sh_q[WORD_W-1];
            default:  line  = 1'b0;
        endcase
    end
endmodule

// File: rtl/link_rx.sv
module link_rx
    import link_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int TICK_DIV = 1,
    parameter int OVS      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              rd,
    input  logic              ovr_clr,
    output logic [WORD_W-1:0] word,
    output logic              word_valid,
    output logic              overrun
);
    localparam int IW   = $clog2(WORD_W);
    localparam int TW   = $clog2(OVS) + 1;
    localparam int HALF = OVS / 2;

    rx_state_e         st_q, st_d;
    logic [WORD_W-1:0] sh_q, sh_d;
    logic [IW-1:0]     idx_q, idx_d;
    logic [TW-1:0]     tc_q, tc_d;
    logic              sync1_q, sync2_q;
    logic              tick;
    logic              done;
    logic [WORD_W-1:0] word_q;
    logic              valid_q, ovr_q;

    link_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (1'b0),
        .tick    (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= line;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        st_d  = st_q;
        sh_d  = sh_q;
        idx_d = idx_q;
        tc_d  = tc_q;
        done  = 1'b0;
        unique case (st_q)
            RX_HUNT: begin
                if (tick && sync2_q) begin
                    tc_d = '0;
                    st_d = RX_START_CHK;
                end
            end
            RX_START_CHK: begin
                if (tick) begin
                    if (tc_q == TW'(HALF - 1)) begin
                        tc_d  = '0;
                        idx_d = IW'(WORD_W - 1);
                        st_d  = sync2_q ? RX_DATA : RX_HUNT;
                    end else begin
                        tc_d = tc_q + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (tc_q == TW'(OVS - 1)) begin
                        tc_d = '0;
                        sh_d = {sh_q[WORD_W-2:0], sync2_q};
                        if (idx_q == '0) begin
                            done = 1'b1;
                            st_d = RX_DRAIN;
                        end else begin
                            idx_d = idx_q - 1'b1;
                        end
                    end else begin
                        tc_d = tc_q + 1'b1;
                    end
                end
            end
            RX_DRAIN: begin
                if (tick && !sync2_q) st_d = RX_HUNT;
            end
            default: st_d = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_HUNT;
            sh_q  <= '0;
            idx_q <= '0;
            tc_q  <= '0;
        end else begin
            st_q  <= st_d;
            sh_q  <= sh_d;
            idx_q <= idx_d;
            tc_q  <= tc_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (done) begin
                word_q  <= sh_d;
                valid_q <= 1'b1;
            end else if (rd) begin
                valid_q <= 1'b0;
            end
            if (done && valid_q && !rd) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign word       = word_q;
    assign word_valid = valid_q;
    assign overrun    = ovr_q;
endmodule

// File: rtl/serial_word_link.sv
module serial_word_link #(
    parameter int WORD_W          = 24,
    parameter int TX_CLKS_PER_BIT = 10,
    parameter int RX_TICK_DIV     = 1,
    parameter int RX_OVS          = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    input  logic              rx_line,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_rd,
    output logic              rx_overrun,
    input  logic              ovr_clr
);
    link_tx #(
        .WORD_W       (WORD_W),
        .CLKS_PER_BIT (TX_CLKS_PER_BIT)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .data  (tx_data),
        .valid (tx_valid),
        .ready (tx_ready),
        .line  (tx_line)
    );

    link_rx #(
        .WORD_W   (WORD_W),
        .TICK_DIV (RX_TICK_DIV),
        .OVS      (RX_OVS)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .line       (rx_line),
        .rd         (rx_rd),
        .ovr_clr    (ovr_clr),
        .word       (rx_data),
        .word_valid (rx_valid),
        .overrun    (rx_overrun)
    );
endmodule

// File: rtl/serial_word_link_chk.sv
module serial_word_link_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_line,
    input logic rx_valid,
    input logic rx_rd,
    input logic rx_overrun,
    input logic ovr_clr
);
    // R3
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !tx_line);

    // R2
    accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && tx_line));

    // R6
    valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_rd) |=> rx_valid);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun);

    // R8
    overrun_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> rx_valid);
endmodule

bind serial_word_link serial_word_link_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_line    (tx_line),
    .rx_valid   (rx_valid),
    .rx_rd      (rx_rd),
    .rx_overrun (rx_overrun),
    .ovr_clr    (ovr_clr)
);

// File: tb/serial_word_link_tb.sv
module serial_word_link_tb;
    localparam int W   = 24;
    localparam int TXB = 8;
    localparam int TKD = 2;
    localparam int OVS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready, tx_line;
    logic         rx_line;
    logic [W-1:0] rx_data;
    logic         rx_valid, rx_overrun;
    logic         mon_rd = 1'b0, man_rd = 1'b0;
    logic         ovr_clr = 1'b0;
    logic         man_sel = 1'b0, man_line = 1'b0;
    logic         auto_rd = 1'b1;
    logic         rx_rd;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [W-1:0] exp_q[$];

    assign rx_line = man_sel ? man_line : tx_line;
    assign rx_rd   = mon_rd | man_rd;

    always #4 clk = ~clk;

    serial_word_link #(
        .WORD_W(W), .TX_CLKS_PER_BIT(TXB), .RX_TICK_DIV(TKD), .RX_OVS(OVS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_line(tx_line), .rx_line(rx_line),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd),
        .rx_overrun(rx_overrun), .ovr_clr(ovr_clr)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: pops expected words as the receiver presents them (R5)
    always @(negedge clk) begin
        mon_rd <= 1'b0;
        if (rst_n && auto_rd && rx_valid && !mon_rd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected word", rx_data, '0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R5 received word", rx_data, e);
            end
            mon_rd <= 1'b1;
        end
    end

    // driver: sends one word, checks frame bits and ready window (R2, R4)
    task automatic send(input logic [W-1:0] w);
        logic [W-1:0] seen;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = w;
        tx_valid = 1'b1;
        @(posedge clk);
        exp_q.push_back(w);
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (TXB/2) @(negedge clk);
        check(tx_line == 1'b1, "R4 marker bit high", W'(tx_line), W'(1));
        for (int k = W-1; k >= 0; k--) begin
            repeat (TXB) @(negedge clk);
            seen[k] = tx_line;
        end
        check(seen == w, "R4 payload MSB first", seen, w);
        repeat (TXB/2 - 1) @(negedge clk);
        check(tx_ready == 1'b0, "R2 ready low to end of frame", W'(tx_ready), W'(0));
        @(negedge clk);
        check(tx_ready == 1'b1, "R2 ready back after frame", W'(tx_ready), W'(1));
        check(tx_line == 1'b0, "R3 idle line low", W'(tx_line), W'(0));
        repeat (TXB) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx_line == 0 && tx_ready == 1 && rx_valid == 0 && rx_overrun == 0,
              "R1 reset state", {20'd0, tx_line, tx_ready, rx_valid, rx_overrun}, 24'h4);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        send(24'hA5C3F0);
        send(24'h800000);
        send(24'h000001);
        send(24'hFFFFFF);
        send(24'h000000);
        send(24'h123456);
        repeat (40*TXB) @(negedge clk);
        check(exp_q.size() == 0, "R5 all words delivered", W'(exp_q.size()), '0);
        check(rx_overrun == 0, "R8 no overrun when read in time", W'(rx_overrun), '0);

        // R7: short glitch on the receive line
        man_sel  = 1'b1;
        man_line = 1'b1;
        repeat (3) @(negedge clk);
        man_line = 1'b0;
        repeat (40*TXB) @(negedge clk);
        check(rx_valid == 0, "R7 glitch rejected", W'(rx_valid), '0);
        man_sel = 1'b0;

        // R8 / R6: two words with no read
        auto_rd = 1'b0;
        send(24'h0F0F0F);
        send(24'hC0FFEE);
        repeat (10*TXB) @(negedge clk);
        exp_q.delete();
        check(rx_valid == 1, "R6 valid held while unread", W'(rx_valid), W'(1));
        check(rx_overrun == 1, "R8 overrun raised", W'(rx_overrun), W'(1));
        check(rx_data == 24'hC0FFEE, "R8 newer word kept", rx_data, 24'hC0FFEE);
        repeat (20) @(negedge clk);
        check(rx_overrun == 1, "R9 overrun sticky", W'(rx_overrun), W'(1));
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        check(rx_valid == 0, "R6 read clears valid", W'(rx_valid), '0);
        check(rx_overrun == 1, "R9 read leaves overrun", W'(rx_overrun), W'(1));
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check(rx_overrun == 0, "R9 clear drops overrun", W'(rx_overrun), '0);

        auto_rd = 1'b1;
        send(24'h5A5A5A);
        repeat (40*TXB) @(negedge clk);
        check(exp_q.size() == 0, "R5 word after overrun clear", W'(exp_q.size()), '0);
        finish_run();
    end
endmodule